// File: doc/BRIEF.md
# Fetch-Stage Next-PC Predictor

This block guesses, in the same cycle as the instruction memory read, the address the front end should fetch next. Three structures feed the guess. A direct-mapped target buffer is tagged with the full fetch address. A one-bit direction table is indexed by the word address XORed with a global outcome history. An eight-deep return stack is pushed and popped by call and return flags that arrive with the fetched word.

The execute stage reports each resolved branch back through a resolution port. That report carries the branch address, the outcome, the target and the history value that was shown when the branch was predicted. The prediction is purely combinational from the fetch inputs and the registered state. Every update lands at the next clock edge, so a prediction never sees an update made in its own cycle.

Top module: `bp_fetch_predictor`

## Requirements
- R1: Reset invalidates every target-buffer entry, sets every direction bit to not-taken, clears the history and empties the return stack, so the first prediction after reset is fetch_pc+4 with pred_hist equal to 0.
- R2: When fetch_is_ret is low, pred_next_pc is the stored target when the target-buffer entry at fetch_pc[5:2] is valid, its tag equals the full fetch_pc and the direction bit reads 1 (taken). Otherwise it is fetch_pc+4. A tag mismatch gives fetch_pc+4 even when the direction bit is 1.
- R3: Only a resolution with res_is_branch=1 and res_taken=1 writes the target buffer: tag res_pc, target res_target, entry valid. A not-taken resolution leaves the entry untouched, and a later taken one overwrites the target.
- R4: The direction index is fetch_pc[9:2] XOR the zero-extended history. A resolution writes res_taken (1 taken, 0 not-taken) at res_pc[9:2] XOR the zero-extended res_hist.
- R5: Each resolution with res_is_branch=1 shifts res_taken into bit 0 of the 6-bit history and drops the oldest bit. pred_hist always shows the current history.
- R6: A resolution with res_is_branch=0 changes neither the history, the direction table nor the target buffer.
- R7: fetch_is_call pushes fetch_pc+4. fetch_is_ret pops the most recent entry and uses it as pred_next_pc, in last-in first-out order.
- R8: A return with an empty stack predicts fetch_pc+4 and leaves the stack empty.
- R9: Pushing past 8 entries overwrites the oldest. The 8 most recent return addresses stay poppable, and the pop after them underflows.
- R10: When fetch_is_call and fetch_is_ret are high together, the return is served and the call push is dropped.
- R11: A resolution in the same cycle as a fetch of the same address does not affect that cycle's prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| fetch_is_call | input | 1 | Pre-decode flag: fetched word is a call |
| fetch_is_ret | input | 1 | Pre-decode flag: fetched word is a return |
| res_is_branch | input | 1 | Resolution port carries a resolved branch this cycle |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Resolved outcome, 1 = taken |
| res_target | input | 32 | Resolved target address |
| res_hist | input | 6 | History value shown when the branch was predicted |
| pred_next_pc | output | 32 | Predicted next fetch address |
| pred_hist | output | 6 | Current global history, to travel with the branch |

## Verification
The hardest state to reach is a direction bit set to taken at exactly the index a later fetch will use. Every resolution also shifts the history, so the index moves as soon as the bit is written. The stimulus works the shifted history out ahead of time and sends a res_hist chosen so that the XOR lands on the index of the next fetch. The same trick sets up an aliasing branch at another address, which shows a tag mismatch overriding a taken direction bit. The return stack is driven ten calls deep and then popped nine times, to expose wrap-around and underflow together.

// File: rtl/bp_pkg.sv
package bp_pkg;
    // Byte size of one instruction word and the address bits below it.
    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned ALIGN_W    = 2;

    // Where the next fetch address comes from.
    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BTB = 2'd1,
        SRC_RAS = 2'd2
    } pred_src_e;
endpackage

// File: rtl/bp_btb.sv
module bp_btb
    import bp_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    input  logic            wr_en,
    input  logic [PC_W-1:0] wr_pc,
    input  logic [PC_W-1:0] wr_target
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic            valid;
        logic [PC_W-1:0] tag;
        logic [PC_W-1:0] target;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
    } state_t;

    state_t           st_d, st_q;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] wr_idx;

    assign lk_idx = lk_pc[ALIGN_W +: IDX_W];
    assign wr_idx = wr_pc[ALIGN_W +: IDX_W];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx].valid  = 1'b1;
            st_d.ent[wr_idx].tag    = wr_pc;
            st_d.ent[wr_idx].target = wr_target;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Full-address tag compare: a hit is the only thing marking a branch.
    assign lk_hit    = st_q.ent[lk_idx].valid && (st_q.ent[lk_idx].tag == lk_pc);
    assign lk_target = st_q.ent[lk_idx].target;
endmodule

// File: rtl/bp_dir_table.sv
module bp_dir_table #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_word,
    output logic              lk_taken,
    output logic [HIST_W-1:0] hist,
    input  logic              upd_en,
    input  logic [IDX_W-1:0]  upd_word,
    input  logic [HIST_W-1:0] upd_hist,
    input  logic              upd_taken
);
    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam int unsigned PAD_W = IDX_W - HIST_W;

    typedef struct packed {
        logic [DEPTH-1:0]  dir;
        logic [HIST_W-1:0] ghr;
    } state_t;

    state_t           st_d, st_q;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] upd_idx;

    assign lk_idx  = lk_word  ^ {{PAD_W{1'b0}}, st_q.ghr};
    assign upd_idx = upd_word ^ {{PAD_W{1'b0}}, upd_hist};

    always_comb begin
        st_d = st_q;
        if (upd_en) begin
            st_d.dir[upd_idx] = upd_taken;
            st_d.ghr          = {st_q.ghr[HIST_W-2:0], upd_taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lk_taken = st_q.dir[lk_idx];
    assign hist     = st_q.ghr;
endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [PC_W-1:0]            push_val,
    input  logic                       pop,
    output logic                       pop_valid,
    output logic [PC_W-1:0]            pop_val,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] ent;
        logic [PTR_W-1:0]           ptr;
        logic [CNT_W-1:0]           cnt;
    } state_t;

    state_t           st_d, st_q;
    logic [PTR_W-1:0] top_idx;

    assign top_idx   = st_q.ptr - PTR_W'(1);
    assign pop_valid = (st_q.cnt != '0);
    assign pop_val   = st_q.ent[top_idx];
    assign count     = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (pop) begin
            if (pop_valid) begin
                st_d.ptr = top_idx;
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (push) begin
            // Pointer wraps modulo DEPTH; the oldest slot is overwritten when full.
            st_d.ent[st_q.ptr] = push_val;
            st_d.ptr           = st_q.ptr + PTR_W'(1);
            if (st_q.cnt != CNT_W'(DEPTH)) st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor
    import bp_pkg::*;
#(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned BTB_IDX_W = 4,
    parameter int unsigned DIR_IDX_W = 8,
    parameter int unsigned HIST_W    = 6,
    parameter int unsigned RAS_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   fetch_pc,
    input  logic              fetch_is_call,
    input  logic              fetch_is_ret,
    input  logic              res_is_branch,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic [PC_W-1:0]   res_target,
    input  logic [HIST_W-1:0] res_hist,
    output logic [PC_W-1:0]   pred_next_pc,
    output logic [HIST_W-1:0] pred_hist
);
    localparam int unsigned CNT_W = $clog2(RAS_DEPTH + 1);

    logic [PC_W-1:0]  seq_pc;
    logic             btb_hit;
    logic [PC_W-1:0]  btb_target;
    logic             dir_taken;
    logic             ras_valid;
    logic [PC_W-1:0]  ras_top;
    logic [CNT_W-1:0] ras_count;
    pred_src_e        src;

    assign seq_pc = fetch_pc + PC_W'(INSN_BYTES);

    bp_btb #(
        .PC_W  (PC_W),
        .IDX_W (BTB_IDX_W)
    ) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_pc     (fetch_pc),
        .lk_hit    (btb_hit),
        .lk_target (btb_target),
        .wr_en     (res_is_branch && res_taken),
        .wr_pc     (res_pc),
        .wr_target (res_target)
    );

    bp_dir_table #(
        .IDX_W  (DIR_IDX_W),
        .HIST_W (HIST_W)
    ) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_word   (fetch_pc[ALIGN_W +: DIR_IDX_W]),
        .lk_taken  (dir_taken),
        .hist      (pred_hist),
        .upd_en    (res_is_branch),
        .upd_word  (res_pc[ALIGN_W +: DIR_IDX_W]),
        .upd_hist  (res_hist),
        .upd_taken (res_taken)
    );

    // A return outranks a call flagged in the same cycle.
    bp_ras #(
        .PC_W  (PC_W),
        .DEPTH (RAS_DEPTH)
    ) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fetch_is_call && !fetch_is_ret),
        .push_val  (seq_pc),
        .pop       (fetch_is_ret),
        .pop_valid (ras_valid),
        .pop_val   (ras_top),
        .count     (ras_count)
    );

    always_comb begin
        if (fetch_is_ret)              src = ras_valid ? SRC_RAS : SRC_SEQ;
        else if (btb_hit && dir_taken) src = SRC_BTB;
        else                           src = SRC_SEQ;
        unique case (src)
            SRC_BTB: pred_next_pc = btb_target;
            SRC_RAS: pred_next_pc = ras_top;
            default: pred_next_pc = seq_pc;
        endcase
    end
endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned HIST_W    = 6,
    parameter int unsigned RAS_DEPTH = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [PC_W-1:0]                fetch_pc,
    input logic                           fetch_is_call,
    input logic                           fetch_is_ret,
    input logic                           res_is_branch,
    input logic                           res_taken,
    input logic [PC_W-1:0]                pred_next_pc,
    input logic [HIST_W-1:0]              pred_hist,
    input logic [$clog2(RAS_DEPTH+1)-1:0] ras_count
);
    localparam int unsigned CNT_W = $clog2(RAS_DEPTH + 1);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pred_hist == '0) && (ras_count == '0));

    assert_hist_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_is_branch |=> pred_hist[0] == $past(res_taken));

    assert_hist_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !res_is_branch |=> pred_hist == $past(pred_hist));

    assert_pop_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_is_ret && ras_count != '0) |=> ras_count == $past(ras_count) - CNT_W'(1));

    assert_underflow_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_is_ret && ras_count == '0) |-> pred_next_pc == fetch_pc + PC_W'(4));

    assert_underflow_stay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_is_ret && ras_count == '0) |=> ras_count == '0);

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ras_count <= CNT_W'(RAS_DEPTH));

    assert_full_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_is_call && !fetch_is_ret && ras_count == CNT_W'(RAS_DEPTH))
        |=> ras_count == CNT_W'(RAS_DEPTH));

    assert_ret_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_is_call && fetch_is_ret) |=> ras_count <= $past(ras_count));
endmodule

bind bp_fetch_predictor bp_checker #(
    .PC_W      (PC_W),
    .HIST_W    (HIST_W),
    .RAS_DEPTH (RAS_DEPTH)
) i_bp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_pc      (fetch_pc),
    .fetch_is_call (fetch_is_call),
    .fetch_is_ret  (fetch_is_ret),
    .res_is_branch (res_is_branch),
    .res_taken     (res_taken),
    .pred_next_pc  (pred_next_pc),
    .pred_hist     (pred_hist),
    .ras_count     (ras_count)
);

// File: tb/test_bp_fetch_predictor.sv
module test_bp_fetch_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_is_call = 1'b0;
    logic        fetch_is_ret = 1'b0;
    logic        res_is_branch = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic [5:0]  res_hist = '0;
    logic [31:0] pred_next_pc;
    logic [5:0]  pred_hist;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bit          q_chk[$];
    logic [31:0] q_pc[$];
    logic [5:0]  q_h[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    bp_fetch_predictor i_bp_fetch_predictor (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_pc      (fetch_pc),
        .fetch_is_call (fetch_is_call),
        .fetch_is_ret  (fetch_is_ret),
        .res_is_branch (res_is_branch),
        .res_pc        (res_pc),
        .res_taken     (res_taken),
        .res_target    (res_target),
        .res_hist      (res_hist),
        .pred_next_pc  (pred_next_pc),
        .pred_hist     (pred_hist)
    );

    // Driver: apply one cycle of stimulus and queue what must appear.
    task automatic step(input logic [31:0] pc, input logic call, input logic ret,
                        input logic rb, input logic rt, input logic [31:0] rpc,
                        input logic [31:0] rtgt, input logic [5:0] rh,
                        input logic [31:0] exp_pc, input logic [5:0] exp_h,
                        input string tag);
        @(negedge clk);
        #1;
        fetch_pc = pc; fetch_is_call = call; fetch_is_ret = ret;
        res_is_branch = rb; res_taken = rt; res_pc = rpc;
        res_target = rtgt; res_hist = rh;
        q_chk.push_back(1'b1);
        q_pc.push_back(exp_pc);
        q_h.push_back(exp_h);
        q_tag.push_back(tag);
    endtask

    task automatic fetch(input logic [31:0] pc, input logic call, input logic ret,
                         input logic [31:0] exp_pc, input logic [5:0] exp_h,
                         input string tag);
        step(pc, call, ret, 1'b0, 1'b0, 32'h0, 32'h0, 6'h0, exp_pc, exp_h, tag);
    endtask

    // Monitor: compare the combinational prediction mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q_chk.size() > 0) begin
                bit          c;
                logic [31:0] e_pc;
                logic [5:0]  e_h;
                string       t;
                c = q_chk.pop_front(); e_pc = q_pc.pop_front();
                e_h = q_h.pop_front(); t = q_tag.pop_front();
                if (c) begin
                    checks++;
                    if (pred_next_pc !== e_pc) begin
                        errors++;
                        $display("FAIL %s pred_next_pc actual %h expected %h", t, pred_next_pc, e_pc);
                    end
                    checks++;
                    if (pred_hist !== e_h) begin
                        errors++;
                        $display("FAIL %s pred_hist actual %h expected %h", t, pred_hist, e_h);
                    end
                end
            end
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty state after reset
        fetch(32'h100, 0, 0, 32'h104, 6'h00, "R1");
        // R11: resolving 0x200 in the fetch cycle of 0x200 does not affect it
        step(32'h200, 0, 0, 1, 1, 32'h200, 32'h400, 6'h00, 32'h204, 6'h00, "R11");
        // R4: history moved to 1, index 0x81 is clear; plant bit at 0x83
        step(32'h200, 0, 0, 1, 1, 32'h200, 32'h400, 6'h03, 32'h204, 6'h01, "R4");
        // R2: hit and taken; also plant 0x97 via aliasing branch 0x244
        step(32'h200, 0, 0, 1, 1, 32'h244, 32'h500, 6'h06, 32'h400, 6'h03, "R2");
        // R2: taken direction but tag mismatch at 0x240
        fetch(32'h240, 0, 0, 32'h244, 6'h07, "R2");
        // R3: not-taken resolution of 0x280 (same slot) must not write the buffer
        step(32'h300, 0, 0, 1, 0, 32'h280, 32'h999, 6'h00, 32'h304, 6'h07, "R3");
        step(32'h300, 0, 0, 1, 1, 32'h204, 32'h600, 6'h1C, 32'h304, 6'h0E, "R5");
        fetch(32'h200, 0, 0, 32'h400, 6'h1D, "R3");
        // R6: resolution port without res_is_branch is ignored
        step(32'h100, 0, 0, 0, 1, 32'h200, 32'h777, 6'h3F, 32'h104, 6'h1D, "R6");
        fetch(32'h200, 0, 0, 32'h400, 6'h1D, "R6");
        // R3: taken resolution overwrites the target
        step(32'h300, 0, 0, 1, 1, 32'h200, 32'h480, 6'h3B, 32'h304, 6'h1D, "R3");
        step(32'h200, 0, 0, 1, 0, 32'h100, 32'h0, 6'h00, 32'h480, 6'h3B, "R3");
        // R5: oldest history bit drops out (0x3B -> 0x36)
        fetch(32'h100, 0, 0, 32'h104, 6'h36, "R5");
        // R7: calls then returns in LIFO order
        fetch(32'h1000, 1, 0, 32'h1004, 6'h36, "R7");
        fetch(32'h2000, 1, 0, 32'h2004, 6'h36, "R7");
        fetch(32'h3000, 0, 1, 32'h2004, 6'h36, "R7");
        fetch(32'h3100, 0, 1, 32'h1004, 6'h36, "R7");
        // R8: underflow
        fetch(32'h3200, 0, 1, 32'h3204, 6'h36, "R8");
        // R10: call and return together: return served, push dropped
        fetch(32'h3300, 1, 1, 32'h3304, 6'h36, "R10");
        fetch(32'h3400, 0, 1, 32'h3404, 6'h36, "R10");
        // R9: ten pushes, eight pops of the newest, then underflow
        for (int k = 0; k < 10; k++) begin
            fetch(32'h4000 + 32'(k * 16), 1, 0, 32'h4004 + 32'(k * 16), 6'h36, "R9");
        end
        for (int k = 9; k >= 2; k--) begin
            fetch(32'h5000, 0, 1, 32'h4004 + 32'(k * 16), 6'h36, "R9");
        end
        fetch(32'h5000, 0, 1, 32'h5004, 6'h36, "R9");
        @(negedge clk);
        #1;
        fetch_is_call = 1'b0; fetch_is_ret = 1'b0; res_is_branch = 1'b0;
        repeat (2) @(negedge clk);
        #10;
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule